// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide first-in first-out buffer whose write side and read side run on independent clocks. The write side stores one word per write-clock edge while its active-low write enable is asserted. The read side moves the oldest stored word into an output register on each read-clock edge while its active-low read enable is asserted. Five active-low status flags report the fill level: empty, full, more than half full, almost empty and almost full. The two "almost" flags trip at distances that software sets.

Those two distances live in a pair of 12-bit threshold registers. They are loaded and read back over the normal data path while an active-low load strobe is held. Each side keeps a two-position selector that alternates between the empty-side and the full-side threshold. The selector keeps its position when the load strobe is released, so a partial programming pass resumes where it stopped. Read and write pointers carry a wrap bit. They cross between the clock domains as Gray code through two-stage synchronisers, so the full-side flags follow the write clock and the empty-side flags follow the read clock. An output-drive indication stands in for three-state output pads.

The depth is set by an address-width parameter: 8 gives 256 words and 12 gives 4096 words.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain returns to its idle state. Afterwards `empty_n` and `aempty_n` are low, `full_n`, `afull_n` and `half_n` are high, `dout` is zero, both thresholds hold 7, and both selectors point at the empty-side threshold.
- R2: With `load_n` high, each write-clock edge with `wr_en_n` low stores `din`. Each read-clock edge with `rd_en_n` low loads the oldest stored word into `dout`. Words leave in the order they entered.
- R3: `full_n` is low exactly when the write side sees DEPTH words stored. A write attempted while full is dropped, and the stored contents are unchanged.
- R4: `empty_n` is low exactly when the read side sees zero words stored. A read attempted while empty is dropped, and `dout` keeps the last word read.
- R5: `half_n` is low exactly when the stored word count exceeds DEPTH/2.
- R6: `aempty_n` is low exactly when the stored word count is less than or equal to the empty-side threshold.
- R7: `afull_n` is low exactly when the free space (DEPTH minus count) is less than or equal to the full-side threshold.
- R8: With `load_n` low, each write-clock edge with `wr_en_n` low copies `din[11:0]` into the threshold that the write selector names, then flips the selector. The order is empty-side first, then full-side, then back to empty-side. The selector keeps its position while `load_n` is high. Such writes never enter the FIFO.
- R9: With `load_n` low, each read-clock edge with `rd_en_n` low places the threshold named by the read selector on `dout[11:0]`, with bits 17:12 zero, then flips the selector. The order is empty-side first. The FIFO read position does not move.
- R10: With `load_n` low and both enables high, nothing changes: no threshold, no selector and no FIFO state.
- R11: `q_oe` is high exactly when `out_en_n` is low.
- R12: The Gray-coded pointers passed between the domains change by at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| load_n | input | 1 | Active-low threshold access select |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data; bits 11:0 carry a threshold during programming |
| rd_en_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output drive request |
| dout | output | 18 | Registered read data or threshold readback |
| q_oe | output | 1 | High when the output would be driven |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when at or below the empty-side threshold (read clock) |
| half_n | output | 1 | Low when more than half full (write clock) |
| afull_n | output | 1 | Low when free space is at or below the full-side threshold (write clock) |
| full_n | output | 1 | Low when full (write clock) |

## Verification
A write or read pointer that takes a wrong step shows up as a flag level that disagrees with the arithmetic count once the crossing settles, a few cycles later. It shows up again as a wrong or missing word when the FIFO is drained. A threshold selector that restarts or sticks is exposed on the very next readback edge through `dout[11:0]`. A threshold written into the wrong register moves the almost-empty or almost-full trip point by the difference. The bench therefore steps the fill level across every count from empty to full and back, under two threshold settings, and compares every flag at every count.

// File: rtl/pf_pkg.sv
// Package pf_pkg
// Shared definitions for the dual-clock threshold FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pf_pkg;

    // Which threshold register an access selector currently names
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } off_sel_t;

endpackage

// File: rtl/pf_sync.sv
// Module pf_sync
// Two-stage synchroniser for a Gray-coded pointer entering a clock domain.
// Assumes the source changes at most one bit per source-clock cycle.
module pf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two flop stages; cleared by the synchronous reset of this domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/pf_mem.sv
// Module pf_mem
// Storage array: one registered write port on the write clock and one
// combinational read port consumed by the read-side output register.
// Assumes a location is only read after it has been written (empty guard).
module pf_mem #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Capture one word per enabled write edge
    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Unregistered read of the word at the read pointer
    assign rdata = store[raddr];

endmodule

// File: rtl/pf_wr_side.sv
// Module pf_wr_side
// Write-clock logic: write pointer, Gray pointer output, both threshold
// registers with their programming selector, and the full, almost-full and
// half-full flags.
// Assumes DW >= OW and that rgray_s has already passed through pf_sync.
module pf_wr_side
    import pf_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 18,
    parameter int OW      = 12,
    parameter int OFF_DEF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic          wr_en_n,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic [OW-1:0] empty_off,
    output logic [OW-1:0] full_off,
    output logic          full_n,
    output logic          afull_n,
    output logic          half_n
);

    localparam int DEPTH = 1 << AW;
    localparam int CW    = (OW > AW + 1) ? OW : AW + 1;
    localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);
    localparam logic [AW:0] HALF_C  = (AW + 1)'(DEPTH / 2);

    off_sel_t    sel;
    logic [AW:0] rbin_s;
    logic [AW:0] cnt;
    logic [AW:0] free_w;
    logic [AW:0] wbin_nx;
    logic        is_full;
    logic        do_wr;
    logic        do_ld;

    // Gray to binary for the synchronised read pointer
    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i + 1] ^ g[i];
        return b;
    endfunction

    // Occupancy as seen from the write domain and the resulting strobes
    always_comb begin
        rbin_s  = g2b(rgray_s);
        cnt     = wbin - rbin_s;
        free_w  = DEPTH_C - cnt;
        is_full = (cnt == DEPTH_C);
        do_wr   = load_n && !wr_en_n && !is_full;
        do_ld   = !load_n && !wr_en_n;
        wbin_nx = do_wr ? wbin + 1'b1 : wbin;
    end

    // Write pointer and its registered Gray image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Threshold programming with an alternating, persistent selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_off <= OW'(OFF_DEF);
            full_off  <= OW'(OFF_DEF);
            sel       <= SEL_EMPTY;
        end else if (do_ld) begin
            if (sel == SEL_EMPTY) empty_off <= din[OW-1:0];
            else                  full_off  <= din[OW-1:0];
            sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
        end
    end

    // Write-domain flags, all active low
    always_comb begin
        full_n  = !is_full;
        half_n  = !(cnt > HALF_C);
        afull_n = !(CW'(free_w) <= CW'(full_off));
    end

    assign mem_we    = do_wr;
    assign mem_waddr = wbin[AW-1:0];

endmodule

// File: rtl/pf_rd_side.sv
// Module pf_rd_side
// Read-clock logic: read pointer, output register, threshold readback
// selector, and the empty and almost-empty flags.
// Assumes thresholds are quasi-static: they are not reprogrammed while the
// read side samples them for flags or readback.
module pf_rd_side
    import pf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18,
    parameter int OW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic          rd_en_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    input  logic [OW-1:0] empty_off,
    input  logic [OW-1:0] full_off,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          aempty_n
);

    localparam int CW = (OW > AW + 1) ? OW : AW + 1;

    off_sel_t    sel;
    logic [AW:0] wbin_s;
    logic [AW:0] cnt;
    logic [AW:0] rbin_nx;
    logic        is_empty;
    logic        do_rd;
    logic        do_rb;

    // Gray to binary for the synchronised write pointer
    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i + 1] ^ g[i];
        return b;
    endfunction

    // Occupancy as seen from the read domain and the resulting strobes
    always_comb begin
        wbin_s   = g2b(wgray_s);
        cnt      = wbin_s - rbin;
        is_empty = (cnt == '0);
        do_rd    = load_n && !rd_en_n && !is_empty;
        do_rb    = !load_n && !rd_en_n;
        rbin_nx  = do_rd ? rbin + 1'b1 : rbin;
    end

    // Read pointer and its registered Gray image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Output register: FIFO word, threshold readback, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            sel  <= SEL_EMPTY;
        end else if (do_rb) begin
            dout <= DW'((sel == SEL_EMPTY) ? empty_off : full_off);
            sel  <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
        end else if (do_rd) begin
            dout <= mem_rdata;
        end
    end

    // Read-domain flags, active low
    always_comb begin
        empty_n  = !is_empty;
        aempty_n = !(CW'(cnt) <= CW'(empty_off));
    end

    assign mem_raddr = rbin[AW-1:0];

endmodule

// File: rtl/dcfifo_pflag.sv
// Module dcfifo_pflag
// Dual-clock FIFO with five active-low status flags and two programmable
// 12-bit thresholds reached over the data path while load_n is low.
// Assumes rst_n is held low across at least three edges of each clock and
// that no read or write is requested while it is low.
module dcfifo_pflag #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 18,
    parameter int OFF_W   = 12,
    parameter int OFF_DEF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dout,
    output logic              q_oe,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W:0]   w_bin;
    logic [ADDR_W:0]   w_gray;
    logic [ADDR_W:0]   r_bin;
    logic [ADDR_W:0]   r_gray;
    logic [ADDR_W:0]   w_gray_s;
    logic [ADDR_W:0]   r_gray_s;
    logic [OFF_W-1:0]  empty_off;
    logic [OFF_W-1:0]  full_off;

    pf_wr_side #(
        .AW(ADDR_W), .DW(DATA_W), .OW(OFF_W), .OFF_DEF(OFF_DEF)
    ) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
        .din(din), .rgray_s(r_gray_s), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .wbin(w_bin), .wgray(w_gray),
        .empty_off(empty_off), .full_off(full_off),
        .full_n(full_n), .afull_n(afull_n), .half_n(half_n)
    );

    pf_rd_side #(
        .AW(ADDR_W), .DW(DATA_W), .OW(OFF_W)
    ) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .load_n(load_n), .rd_en_n(rd_en_n),
        .wgray_s(w_gray_s), .mem_rdata(mem_rdata),
        .empty_off(empty_off), .full_off(full_off),
        .mem_raddr(mem_raddr), .rbin(r_bin), .rgray(r_gray),
        .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    pf_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
    );

    pf_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s)
    );

    pf_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    // Output-drive indication standing in for three-state pads
    assign q_oe = !out_en_n;

endmodule

// File: rtl/pf_chk.sv
// Module pf_chk
// Temporal checks on the dual-clock FIFO, attached to dcfifo_pflag by bind.
// Assumes the bench holds rst_n low from time zero.
module pf_chk #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          load_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [DW-1:0] dout,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   r_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_gray
);

    // R1
    reset_state_chk: assert property (@(posedge rd_clk)
        !rst_n |=> (dout == '0) && !empty_n);

    // R3
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n) |=> $stable(w_bin));

    // R4
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n && load_n) |=> $stable(r_bin) && $stable(dout));

    // R6
    aempty_order_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R7
    afull_order_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R8
    load_wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !load_n |=> $stable(w_bin));

    // R9
    load_rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !load_n |=> $stable(r_bin));

    // R12
    wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R12
    rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);

endmodule

bind dcfifo_pflag pf_chk #(.AW(ADDR_W), .DW(DATA_W)) u_pf_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .full_n(full_n),
    .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .dout(dout), .w_bin(w_bin), .r_bin(r_bin),
    .w_gray(w_gray), .r_gray(r_gray)
);

// File: tb/test_dcfifo_pflag.sv
// Bench for dcfifo_pflag on a 16-word configuration: every fill level from
// empty to full and back, under default and programmed thresholds.
module test_dcfifo_pflag;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        q_oe, empty_n, aempty_n, half_n, afull_n, full_n;

    int n_chk = 0;
    int n_fail = 0;
    int eoff = 7;
    int foff = 7;
    logic [17:0] model [$];
    logic [17:0] last_rd = '0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dcfifo_pflag #(.ADDR_W(AW)) i_dcfifo_pflag (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .load_n(load_n),
        .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n),
        .out_en_n(out_en_n), .dout(dout), .q_oe(q_oe),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
    endtask

    // Compare all five flags against the count arithmetic
    task automatic check_flags(input int c);
        chk("R4 empty_n",  int'(empty_n),  int'(c != 0));
        chk("R3 full_n",   int'(full_n),   int'(c != DEPTH));
        chk("R5 half_n",   int'(half_n),   int'(!(c > DEPTH / 2)));
        chk("R6 aempty_n", int'(aempty_n), int'(!(c <= eoff)));
        chk("R7 afull_n",  int'(afull_n),  int'(!((DEPTH - c) <= foff)));
    endtask

    task automatic wr_word(input logic [17:0] d);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        din = d;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic rd_word();
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        if (model.size() > 0) last_rd = model.pop_front();
        chk("R2/R4 dout", int'(dout), int'(last_rd));
    endtask

    task automatic ld_write(input logic [11:0] v);
        @(negedge wr_clk);
        load_n = 1'b0;
        wr_en_n = 1'b0;
        din = {6'h15, v};
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        load_n = 1'b1;
    endtask

    task automatic ld_read(input int exp);
        @(negedge rd_clk);
        load_n = 1'b0;
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        load_n = 1'b1;
        chk("R9 readback", int'(dout), exp);
    endtask

    // Fill to full one word at a time, try one overflow, drain, try underflow
    task automatic sweep(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(18'((i * 2647 + seed) ^ 18'h2A5A5));
            settle();
            check_flags(model.size());
        end
        wr_word(18'h3FFFF);          // R3 overflow attempt
        settle();
        check_flags(model.size());
        chk("R3 count after overflow", model.size(), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            rd_word();
            settle();
            check_flags(model.size());
        end
        rd_word();                   // R4 underflow attempt, dout holds
        settle();
        check_flags(0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 dout", int'(dout), 0);
        check_flags(0);

        // R11 output drive indication
        chk("R11 q_oe off", int'(q_oe), 0);
        out_en_n = 1'b0;
        #1;
        chk("R11 q_oe on", int'(q_oe), 1);

        // R2..R7 with default thresholds
        sweep(11);

        // R1 defaults visible through readback; selector starts empty-side
        ld_read(7);
        ld_read(7);

        // R8 program empty-side, pause, then full-side continues
        ld_write(12'd3);
        // R10 load low, enables high: no effect
        @(negedge wr_clk);
        load_n = 1'b0;
        repeat (5) @(negedge rd_clk);
        load_n = 1'b1;
        ld_write(12'd11);
        eoff = 3;
        foff = 11;
        settle();
        check_flags(0);
        ld_read(3);                  // R9 empty-side first
        ld_read(11);
        ld_read(3);                  // R9 wraps
        // R8 third write wraps to the empty-side threshold
        ld_write(12'd2);
        eoff = 2;
        ld_read(11);                 // read selector resumes at full-side
        ld_read(2);

        // R9 readback with data stored does not disturb FIFO order
        wr_word(18'h1234);
        wr_word(18'h2345);
        settle();
        ld_read(11);
        rd_word();
        rd_word();
        settle();
        check_flags(0);

        // Sweep again under programmed thresholds
        sweep(7001);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule